// File: doc/BRIEF.md
# Flag-Generating Adder with Branch Test

This block is the arithmetic end of a small processor datapath. It adds or subtracts two two's-complement operands of a parameterised width (8 bits by default). It can also run a compare, which is a subtraction whose difference is thrown away, or a bit test, which is an AND with a mask whose value is thrown away. Each operation can update four condition flags held in a status register: negative, zero, overflow and carry. Subtraction forms A plus the bitwise inverse of B plus one. Overflow is the exclusive-OR of the carry into the top bit and the carry out of it.

Only add and subtract load the result register and raise the write-back strobe. A flag-enable input gates whether the status register loads on a given edge. A combinational evaluator compares the registered flags with a 3-bit condition code and drives a branch-taken output that the sequencer uses.

Top module: `alu_flag_unit`

## Requirements
- R1: With op_sel=00 (add), one clock edge later result holds (a_in + b_in) mod 2^W and wr_strobe is 1.
- R2: With op_sel=01 (subtract), one edge later result holds a_in + ~b_in + 1 mod 2^W and wr_strobe is 1. The carry flag is the raw carry out of that sum, with no borrow inversion (0xF0 minus 0x14 gives 0xDC with C=1).
- R3: For add, subtract and compare, V is 1 exactly when the carry into bit W-1 differs from the carry out of bit W-1 (0x7F+0x01 gives V=1; 0x80-0x01 gives 0x7F with V=1; 0xFF+0x01 gives V=0).
- R4: N equals bit W-1 of the operation's value, and Z is 1 exactly when every bit of that value is 0. The flags port packs them as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R5: With op_sel=10 (compare), the flags are set as for a subtraction of the same operands. The result is left unchanged and wr_strobe is 0.
- R6: With op_sel=11 (test), N and Z come from a_in & b_in, V and C are cleared, the result is left unchanged and wr_strobe is 0.
- R7: The four flags load only on an edge where flag_en is 1. Otherwise they hold, while the result register still follows add and subtract.
- R8: br_taken is combinational from the registered flags and cond_sel: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=0, 5 N=1, 6 V=1, 7 V=0.
- R9: A synchronous active-high rst clears the flags, the result and wr_strobe to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B or test mask |
| op_sel | input | 2 | 00 add, 01 subtract, 10 compare, 11 test |
| flag_en | input | 1 | Load the status register on this edge |
| cond_sel | input | 3 | Branch condition code |
| result | output | W | Registered sum or difference |
| wr_strobe | output | 1 | Registered write-back strobe, high after add or subtract |
| flags | output | 4 | Registered {N, Z, V, C} |
| br_taken | output | 1 | Branch condition met by the registered flags |

## Verification
Result, wr_strobe and flags are due one edge after the operation is presented. The bench therefore drives each operation on a falling edge and samples on the falling edge that follows the next rising edge. br_taken has no register of its own. It is sampled a short delay after cond_sel changes, while the flags are steady, so each condition code is checked against the same flag state.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_TST = 2'b11
  } op_t;

  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_V = 1;
  localparam int FL_C = 0;
  localparam int FL_W = 4;
endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  localparam int LO = W - 1;

  logic [LO-1:0] b_lo;
  logic          b_hi;
  logic [LO:0]   lo_sum;
  logic [1:0]    hi_sum;

  always_comb begin
    b_lo   = sub ? ~b[LO-1:0] : b[LO-1:0];
    b_hi   = sub ? ~b[W-1] : b[W-1];
    lo_sum = {1'b0, a[LO-1:0]} + {1'b0, b_lo} + {{LO{1'b0}}, sub};
    c_into_msb = lo_sum[LO];
    hi_sum = {1'b0, a[W-1]} + {1'b0, b_hi} + {1'b0, c_into_msb};
    sum    = {hi_sum[0], lo_sum[LO-1:0]};
    c_out  = hi_sum[1];
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flag_pkg::*;
(
  input  logic [FL_W-1:0] fl,
  input  logic [2:0]      cond,
  output logic            taken
);
  logic base;

  always_comb begin
    unique case (cond[2:1])
      2'd0:    base = fl[FL_Z];
      2'd1:    base = fl[FL_C];
      2'd2:    base = ~fl[FL_N];
      default: base = fl[FL_V];
    endcase
    taken = cond[0] ? ~base : base;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   op_sel,
  input  logic         flag_en,
  input  logic [2:0]   cond_sel,
  output logic [W-1:0] result,
  output logic         wr_strobe,
  output logic [3:0]   flags,
  output logic         br_taken
);
  op_t             op;
  logic [W-1:0]    sum;
  logic            c_msb;
  logic            c_out;
  logic [W-1:0]    val;
  logic            arith;
  logic            writes;
  logic [FL_W-1:0] fl_next;
  logic [FL_W-1:0] fl_q;
  logic [W-1:0]    res_q;
  logic            wr_q;

  assign op = op_t'(op_sel);

  addsub_core #(.W(W)) u_core (
    .a          (a_in),
    .b          (b_in),
    .sub        (op != OP_ADD),
    .sum        (sum),
    .c_into_msb (c_msb),
    .c_out      (c_out)
  );

  always_comb begin
    arith  = (op != OP_TST);
    writes = (op == OP_ADD) || (op == OP_SUB);
    val    = arith ? sum : (a_in & b_in);
    fl_next[FL_N] = val[W-1];
    fl_next[FL_Z] = (val == '0);
    fl_next[FL_V] = arith & (c_msb ^ c_out);
    fl_next[FL_C] = arith & c_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q  <= '0;
      res_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      if (flag_en) fl_q <= fl_next;
      if (writes)  res_q <= sum;
      wr_q <= writes;
    end
  end

  cond_eval u_cond (
    .fl    (fl_q),
    .cond  (cond_sel),
    .taken (br_taken)
  );

  assign result    = res_q;
  assign wr_strobe = wr_q;
  assign flags     = fl_q;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op_sel,
  input logic         flag_en,
  input logic [2:0]   cond_sel,
  input logic [W-1:0] result,
  input logic         wr_strobe,
  input logic [3:0]   flags,
  input logic         br_taken
);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags == 4'b0 && result == '0 && !wr_strobe));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> $stable(flags));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10) |=> (!wr_strobe && $stable(result)));

  // R6
  test_cv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_en && op_sel == 2'b11) |=> (flags[1:0] == 2'b00 && !wr_strobe));

  // R4
  add_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_en && op_sel == 2'b00) |=> (flags[2] == (result == '0) && flags[3] == result[W-1]));

  // R1
  add_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b00) |=> wr_strobe);

  // R8
  br_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'd0) |-> (br_taken == flags[2]));

  // R8
  br_nocarry_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'd3) |-> (br_taken == !flags[0]));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_sel    (op_sel),
  .flag_en   (flag_en),
  .cond_sel  (cond_sel),
  .result    (result),
  .wr_strobe (wr_strobe),
  .flags     (flags),
  .br_taken  (br_taken)
);

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  localparam int W = 8;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [1:0]   op_sel = 2'b00;
  logic         flag_en = 1'b0;
  logic [2:0]   cond_sel = 3'd0;
  logic [W-1:0] result;
  logic         wr_strobe;
  logic [3:0]   flags;
  logic         br_taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_flag_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
    .flag_en(flag_en), .cond_sel(cond_sel), .result(result),
    .wr_strobe(wr_strobe), .flags(flags), .br_taken(br_taken)
  );

  // {op, a, b, expected result, expected {N,Z,V,C}}
  localparam logic [29:0] VEC [NV] = '{
    {2'b00, 8'h12, 8'h34, 8'h46, 4'b0000},  // R1
    {2'b00, 8'h7F, 8'h01, 8'h80, 4'b1010},  // R3
    {2'b00, 8'hFF, 8'h01, 8'h00, 4'b0101},  // R3
    {2'b00, 8'h80, 8'h80, 8'h00, 4'b0111},  // R3
    {2'b01, 8'hF0, 8'h14, 8'hDC, 4'b1001},  // R2
    {2'b01, 8'h80, 8'h01, 8'h7F, 4'b0011},  // R3
    {2'b01, 8'h05, 8'h05, 8'h00, 4'b0101},  // R4
    {2'b01, 8'h03, 8'h05, 8'hFE, 4'b1000},  // R2
    {2'b10, 8'h10, 8'h20, 8'h00, 4'b1000},  // R5
    {2'b10, 8'h20, 8'h20, 8'h00, 4'b0101},  // R5
    {2'b11, 8'hB1, 8'h08, 8'h00, 4'b0100},  // R6
    {2'b11, 8'hF0, 8'h80, 8'h00, 4'b1000},  // R6
    {2'b00, 8'h00, 8'h00, 8'h00, 4'b0100}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic fen);
    @(negedge clk);
    op_sel = op; a_in = a; b_in = b; flag_en = fen;
    @(posedge clk);
    @(negedge clk);
    flag_en = 1'b0;
    op_sel = 2'b10;
  endtask

  function automatic logic exp_branch(input logic [3:0] f, input logic [2:0] c);
    case (c)
      3'd0: return f[2] == 1'b1;
      3'd1: return f[2] == 1'b0;
      3'd2: return f[0] == 1'b1;
      3'd3: return f[0] == 1'b0;
      3'd4: return f[3] == 1'b0;
      3'd5: return f[3] == 1'b1;
      3'd6: return f[1] == 1'b1;
      default: return f[1] == 1'b0;
    endcase
  endfunction

  task automatic sweep_branch(input logic [3:0] f);
    for (int c = 0; c < 8; c++) begin
      cond_sel = 3'(c);
      #1;
      check($sformatf("R8 cond %0d flags %b", c, f), {31'b0, br_taken}, {31'b0, exp_branch(f, 3'(c))});
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 flags after reset", {28'b0, flags}, 32'h0);
    check("R9 result after reset", {24'b0, result}, 32'h0);
    check("R9 strobe after reset", {31'b0, wr_strobe}, 32'h0);

    held = '0;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] vop;
      vop = VEC[i][29:28];
      op_sel = vop; a_in = VEC[i][27:20]; b_in = VEC[i][19:12]; flag_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (vop == 2'b00 || vop == 2'b01) begin
        held = VEC[i][11:4];
        check($sformatf("R1/R2 vec %0d result", i), {24'b0, result}, {24'b0, held});
        check($sformatf("R1/R2 vec %0d strobe", i), {31'b0, wr_strobe}, 32'h1);
      end else begin
        check($sformatf("R5/R6 vec %0d result kept", i), {24'b0, result}, {24'b0, held});
        check($sformatf("R5/R6 vec %0d no strobe", i), {31'b0, wr_strobe}, 32'h0);
      end
      check($sformatf("R3/R4 vec %0d flags", i), {28'b0, flags}, {28'b0, VEC[i][3:0]});
    end
    flag_en = 1'b0;
    op_sel = 2'b10;

    // R8 branch evaluation over several flag states
    run_op(2'b11, 8'hB1, 8'h08, 1'b1);  // flags 0100
    sweep_branch(4'b0100);
    run_op(2'b01, 8'h80, 8'h01, 1'b1);  // flags 0011
    sweep_branch(4'b0011);
    run_op(2'b10, 8'h10, 8'h20, 1'b1);  // flags 1000
    sweep_branch(4'b1000);

    // R7 flags hold with flag_en low, result still follows add
    run_op(2'b01, 8'h05, 8'h05, 1'b1);  // flags 0101
    run_op(2'b00, 8'h7F, 8'h01, 1'b0);
    check("R7 flags held", {28'b0, flags}, 32'h5);
    check("R7 result updated", {24'b0, result}, 32'h80);

    // R6 test after nonzero C/V clears them
    run_op(2'b00, 8'h80, 8'h80, 1'b1);  // flags 0111
    run_op(2'b11, 8'h0F, 8'h03, 1'b1);
    check("R6 test clears V and C", {28'b0, flags}, 32'h0);
    check("R6 result kept", {24'b0, result}, 32'h00);

    // R9 reset from a busy state
    run_op(2'b00, 8'hFF, 8'h01, 1'b1);
    @(negedge clk);
    op_sel = 2'b00; a_in = 8'h11; b_in = 8'h22; flag_en = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; flag_en = 1'b0; op_sel = 2'b10;
    check("R9 flags cleared", {28'b0, flags}, 32'h0);
    check("R9 result cleared", {24'b0, result}, 32'h0);
    check("R9 strobe cleared", {31'b0, wr_strobe}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule